// File: doc/BRIEF.md
# Trap Entry and Interrupt Arbiter

This block sits beside the integer pipeline of a processor with a windowed register file. Each clock it looks at the incoming interrupt level and the pending trap code. It decides whether a trap or an interrupt is taken, and if one is, it computes the processor state that follows trap entry. The current state fields, the trap base register and the current and next program counters arrive as inputs. One cycle later the block returns the updated fields, together with a write request that saves the old program counters into the newly selected register window.

A pending trap code of zero means that nothing is pending. Codes 1 to 255 are trap types. Code 0x100 is the reset request. Interrupts take trap types at 16 plus the level. Level 15 cannot be masked. When a trap arrives while traps are disabled, the block does not vector. It enters a sticky error mode and stays there until reset. When neither a trap nor an interrupt is taken, the block passes its inputs straight through to its outputs.

Top module: `trap_entry_unit`

## Requirements
- R1: An interrupt is accepted only when the level is nonzero, traps are enabled, the pending trap code is zero, and the level is either all ones (15) or greater than the processor interrupt level input.
- R2: An accepted interrupt enters trap type 16 + level, and raises `irq_ack` for exactly one cycle with `ack_level` equal to the level.
- R3: A pending trap code from 1 to 255 takes priority over any interrupt and enters that code as the trap type. It pulses `pend_clr` and does not pulse `irq_ack`.
- R4: A pending trap code from 1 to 255 that arrives with traps disabled sets `err_mode` and performs no entry. While `err_mode` is set, no entry occurs and no pending trap is cleared, and only reset clears `err_mode`.
- R5: On entry, `tbr_out[31:12]` equals `tbr_in[31:12]`, `tbr_out[11:4]` holds the trap type, and `tbr_out[3:0]` is zero.
- R6: On entry, `nx_et` is 0, `nx_ps` takes the old `st_s`, and `nx_s` is 1.
- R7: On entry, `nx_cwp` is `st_cwp` minus one, modulo NWIN, so window 0 wraps to window NWIN-1.
- R8: On entry, `sv_we` is high for one cycle. `sv_pc_addr` is (new window × 16 + 17) mod (NWIN × 16) and carries the old `pc_in`. `sv_npc_addr` is (new window × 16 + 18) mod (NWIN × 16) and carries the old `npc_in`.
- R9: On entry, `pc_out` equals the new `tbr_out` and `npc_out` is `pc_out + 4`. When `single_vec` is 1, bits [11:0] of `pc_out` are zero.
- R10: A pending code of 0x100 sets `pc_out` to 0 and `npc_out` to 4, pulses `pend_clr`, blocks interrupts, and performs no entry.
- R11: After reset, `nx_s` is 1, `nx_et`, `nx_ps`, `nx_pil`, `nx_cwp`, `tbr_out` and `pc_out` are 0, `npc_out` is 4, and every pulse output and `err_mode` are 0.
- R12: When no trap, interrupt or reset code applies, the outputs equal the inputs one cycle later and no pulse output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_level | input | IRQ_W | External interrupt level |
| trap_code | input | 9 | Pending trap: 0 none, 1..255 type, 0x100 reset |
| st_et | input | 1 | Traps enabled |
| st_s | input | 1 | Supervisor |
| st_ps | input | 1 | Previous supervisor |
| st_pil | input | IRQ_W | Processor interrupt level |
| st_cwp | input | CWP_W | Current window pointer |
| tbr_in | input | 32 | Trap base register |
| single_vec | input | 1 | All traps enter at the base |
| pc_in | input | 32 | Current PC |
| npc_in | input | 32 | Current next PC |
| nx_et | output | 1 | Updated traps-enabled |
| nx_s | output | 1 | Updated supervisor |
| nx_ps | output | 1 | Updated previous supervisor |
| nx_pil | output | IRQ_W | Updated interrupt level (passed through) |
| nx_cwp | output | CWP_W | Updated window pointer |
| tbr_out | output | 32 | Updated trap base register |
| pc_out | output | 32 | New PC |
| npc_out | output | 32 | New next PC |
| sv_we | output | 1 | Save-write enable |
| sv_pc_addr | output | RA_W | Register index for saved PC |
| sv_pc_data | output | 32 | Saved PC value |
| sv_npc_addr | output | RA_W | Register index for saved next PC |
| sv_npc_data | output | 32 | Saved next PC value |
| entered | output | 1 | Trap entry performed |
| pend_clr | output | 1 | Pending trap consumed |
| irq_ack | output | 1 | Interrupt acknowledge pulse |
| ack_level | output | IRQ_W | Acknowledged level |
| err_mode | output | 1 | Sticky error mode |

## Verification
The bench builds the block with NWIN = 8 and IRQ_W = 4. With these values the window-0 wrap to window 7 can be reached, and the save index wraps from 129 to 1 in a 128-entry file. The non-maskable level is 15, the same as the largest level the processor interrupt level can hold, so the masking comparison and the level-15 exception meet in one vector. With a trap base whose low bits are nonzero, the bench can show that bits [3:0] are cleared and, in single-vector mode, that bits [11:0] are cleared.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;
  localparam int          XLEN        = 32;
  localparam int          TT_W        = 8;
  localparam int          CODE_W      = 9;
  localparam int          BASE_LSB    = 12;
  localparam int          IRQ_TT_BASE = 16;
  localparam int          SAVE_PC_REG = 17;
  localparam logic [CODE_W-1:0] RESET_CODE = 9'h100;
  localparam logic [XLEN-1:0]   RESET_NPC  = 32'd4;

  // Place the trap type into the base register, keep the upper base bits.
  function automatic logic [XLEN-1:0] tbr_with_tt(input logic [XLEN-1:0] tbr,
                                                 input logic [TT_W-1:0] tt);
    return {tbr[XLEN-1:BASE_LSB], tt, 4'b0000};
  endfunction

  // Entry address: either the per-type slot or the bare base.
  function automatic logic [XLEN-1:0] entry_pc(input logic [XLEN-1:0] new_tbr,
                                              input logic single);
    return single ? {new_tbr[XLEN-1:BASE_LSB], {BASE_LSB{1'b0}}} : new_tbr;
  endfunction
endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import trap_entry_pkg::*;
#(
  parameter int IRQ_W = 4
) (
  input  logic [IRQ_W-1:0] level,
  input  logic             et,
  input  logic [IRQ_W-1:0] pil,
  input  logic             pend,
  output logic             accept,
  output logic [TT_W-1:0]  irq_tt
);
  logic nmi;

  always_comb begin
    nmi    = &level;
    accept = (|level) && et && !pend && (nmi || (level > pil));
    irq_tt = TT_W'(IRQ_TT_BASE) + TT_W'(level);
  end
endmodule

// File: rtl/window_step.sv
module window_step
  import trap_entry_pkg::*;
#(
  parameter  int NWIN  = 8,
  localparam int CWP_W = $clog2(NWIN),
  localparam int RA_W  = CWP_W + 4
) (
  input  logic [CWP_W-1:0] cwp,
  output logic [CWP_W-1:0] cwp_new,
  output logic [RA_W-1:0]  pc_slot,
  output logic [RA_W-1:0]  npc_slot
);
  always_comb begin
    cwp_new  = cwp - CWP_W'(1);
    pc_slot  = {cwp_new, 4'b0000} + RA_W'(SAVE_PC_REG);
    npc_slot = {cwp_new, 4'b0000} + RA_W'(SAVE_PC_REG + 1);
  end
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_entry_pkg::*;
#(
  parameter  int NWIN  = 8,
  parameter  int IRQ_W = 4,
  localparam int CWP_W = $clog2(NWIN),
  localparam int RA_W  = CWP_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IRQ_W-1:0]  irq_level,
  input  logic [8:0]        trap_code,
  input  logic              st_et,
  input  logic              st_s,
  input  logic              st_ps,
  input  logic [IRQ_W-1:0]  st_pil,
  input  logic [CWP_W-1:0]  st_cwp,
  input  logic [31:0]       tbr_in,
  input  logic              single_vec,
  input  logic [31:0]       pc_in,
  input  logic [31:0]       npc_in,
  output logic              nx_et,
  output logic              nx_s,
  output logic              nx_ps,
  output logic [IRQ_W-1:0]  nx_pil,
  output logic [CWP_W-1:0]  nx_cwp,
  output logic [31:0]       tbr_out,
  output logic [31:0]       pc_out,
  output logic [31:0]       npc_out,
  output logic              sv_we,
  output logic [RA_W-1:0]   sv_pc_addr,
  output logic [31:0]       sv_pc_data,
  output logic [RA_W-1:0]   sv_npc_addr,
  output logic [31:0]       sv_npc_data,
  output logic              entered,
  output logic              pend_clr,
  output logic              irq_ack,
  output logic [IRQ_W-1:0]  ack_level,
  output logic              err_mode
);
  // Named internal events
  logic             pend_any;
  logic             rst_req;
  logic             trap_req;
  logic             irq_acc;
  logic [TT_W-1:0]  irq_tt;
  logic [TT_W-1:0]  tt_sel;
  logic             do_enter;
  logic             do_err;
  logic             do_reset;
  logic [CWP_W-1:0] cwp_dec;
  logic [RA_W-1:0]  pc_slot;
  logic [RA_W-1:0]  npc_slot;
  logic [31:0]      tbr_new;
  logic [31:0]      pc_new;

  irq_arbiter #(.IRQ_W(IRQ_W)) u_arb (
    .level  (irq_level),
    .et     (st_et),
    .pil    (st_pil),
    .pend   (pend_any),
    .accept (irq_acc),
    .irq_tt (irq_tt)
  );

  window_step #(.NWIN(NWIN)) u_win (
    .cwp      (st_cwp),
    .cwp_new  (cwp_dec),
    .pc_slot  (pc_slot),
    .npc_slot (npc_slot)
  );

  always_comb begin
    pend_any = trap_code != '0;
    rst_req  = trap_code == RESET_CODE;
    trap_req = pend_any && !rst_req;
    tt_sel   = trap_req ? trap_code[TT_W-1:0] : irq_tt;
    do_enter = !err_mode && st_et && (trap_req || irq_acc);
    do_err   = !err_mode && trap_req && !st_et;
    do_reset = !err_mode && rst_req;
    tbr_new  = tbr_with_tt(tbr_in, tt_sel);
    pc_new   = entry_pc(tbr_new, single_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nx_et       <= 1'b0;
      nx_s        <= 1'b1;
      nx_ps       <= 1'b0;
      nx_pil      <= '0;
      nx_cwp      <= '0;
      tbr_out     <= '0;
      pc_out      <= '0;
      npc_out     <= RESET_NPC;
      sv_we       <= 1'b0;
      sv_pc_addr  <= '0;
      sv_pc_data  <= '0;
      sv_npc_addr <= '0;
      sv_npc_data <= '0;
      entered     <= 1'b0;
      pend_clr    <= 1'b0;
      irq_ack     <= 1'b0;
      ack_level   <= '0;
      err_mode    <= 1'b0;
    end else begin
      nx_et       <= st_et;
      nx_s        <= st_s;
      nx_ps       <= st_ps;
      nx_pil      <= st_pil;
      nx_cwp      <= st_cwp;
      tbr_out     <= tbr_in;
      pc_out      <= pc_in;
      npc_out     <= npc_in;
      sv_we       <= 1'b0;
      sv_pc_addr  <= pc_slot;
      sv_pc_data  <= pc_in;
      sv_npc_addr <= npc_slot;
      sv_npc_data <= npc_in;
      entered     <= do_enter;
      pend_clr    <= (do_enter && trap_req) || do_reset;
      irq_ack     <= do_enter && !trap_req;
      ack_level   <= (do_enter && !trap_req) ? irq_level : '0;
      err_mode    <= err_mode || do_err;
      if (do_enter) begin
        nx_et   <= 1'b0;
        nx_ps   <= st_s;
        nx_s    <= 1'b1;
        nx_cwp  <= cwp_dec;
        tbr_out <= tbr_new;
        pc_out  <= pc_new;
        npc_out <= pc_new + 32'd4;
        sv_we   <= 1'b1;
      end else if (do_reset) begin
        pc_out  <= '0;
        npc_out <= RESET_NPC;
      end
    end
  end
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
  parameter  int NWIN  = 8,
  parameter  int IRQ_W = 4,
  localparam int CWP_W = $clog2(NWIN)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CWP_W-1:0] st_cwp,
  input logic [31:0]      pc_in,
  input logic             nx_et,
  input logic             nx_s,
  input logic [CWP_W-1:0] nx_cwp,
  input logic [31:0]      pc_out,
  input logic [31:0]      npc_out,
  input logic             sv_we,
  input logic [31:0]      sv_pc_data,
  input logic             entered,
  input logic             pend_clr,
  input logic             irq_ack,
  input logic             err_mode
);
  AST_ACK_WITH_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> entered); // R2
  AST_CLR_NOT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    pend_clr |-> !irq_ack); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_mode |=> err_mode); // R4
  AST_ERR_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    err_mode |=> !entered); // R4
  AST_ENTRY_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    entered |-> (!nx_et && nx_s)); // R6
  AST_WIN_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
    entered |-> (CWP_W'(nx_cwp + 1'b1) == $past(st_cwp))); // R7
  AST_SAVE_PC: assert property (@(posedge clk) disable iff (!rst_n)
    sv_we |-> (sv_pc_data == $past(pc_in))); // R8
  AST_NPC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    entered |-> (npc_out == pc_out + 32'd4)); // R9
endmodule

bind trap_entry_unit trap_entry_chk #(.NWIN(NWIN), .IRQ_W(IRQ_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .st_cwp     (st_cwp),
  .pc_in      (pc_in),
  .nx_et      (nx_et),
  .nx_s       (nx_s),
  .nx_cwp     (nx_cwp),
  .pc_out     (pc_out),
  .npc_out    (npc_out),
  .sv_we      (sv_we),
  .sv_pc_data (sv_pc_data),
  .entered    (entered),
  .pend_clr   (pend_clr),
  .irq_ack    (irq_ack),
  .err_mode   (err_mode)
);

// File: tb/test_trap_entry_unit.sv
`timescale 1ns/1ps
module test_trap_entry_unit;
  localparam int NW = 8;
  localparam int IW = 4;
  localparam logic [31:0] TBR = 32'h4000_0A5C;
  localparam logic [31:0] PC0 = 32'h0000_0100;
  localparam logic [31:0] NPC0 = 32'h0000_0104;

  typedef struct packed {
    logic [3:0] lvl;
    logic [8:0] code;
    logic       et;
    logic       s;
    logic [3:0] pil;
    logic [2:0] cwp;
    logic       sv;
    logic       x_take;
    logic       x_ack;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{4'd5,  9'h000, 1'b1, 1'b0, 4'd3,  3'd2, 1'b0, 1'b1, 1'b1},
    '{4'd3,  9'h000, 1'b1, 1'b1, 4'd3,  3'd4, 1'b0, 1'b0, 1'b0},
    '{4'd15, 9'h000, 1'b1, 1'b0, 4'd15, 3'd5, 1'b0, 1'b1, 1'b1},
    '{4'd14, 9'h000, 1'b1, 1'b0, 4'd15, 3'd1, 1'b0, 1'b0, 1'b0},
    '{4'd0,  9'h000, 1'b1, 1'b1, 4'd0,  3'd3, 1'b0, 1'b0, 1'b0},
    '{4'd9,  9'h000, 1'b0, 1'b1, 4'd0,  3'd6, 1'b0, 1'b0, 1'b0},
    '{4'd15, 9'h009, 1'b1, 1'b1, 4'd0,  3'd3, 1'b0, 1'b1, 1'b0},
    '{4'd0,  9'h005, 1'b1, 1'b0, 4'd2,  3'd0, 1'b0, 1'b1, 1'b0},
    '{4'd4,  9'h022, 1'b1, 1'b1, 4'd0,  3'd1, 1'b1, 1'b1, 1'b0},
    '{4'd0,  9'h100, 1'b1, 1'b1, 4'd0,  3'd2, 1'b0, 1'b0, 1'b0},
    '{4'd6,  9'h100, 1'b1, 1'b0, 4'd2,  3'd3, 1'b0, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [IW-1:0] irq_level = '0;
  logic [8:0] trap_code = '0;
  logic st_et = 1'b0, st_s = 1'b0, st_ps = 1'b0, single_vec = 1'b0;
  logic [IW-1:0] st_pil = '0;
  logic [2:0] st_cwp = '0;
  logic [31:0] tbr_in = TBR, pc_in = PC0, npc_in = NPC0;
  logic nx_et, nx_s, nx_ps, sv_we, entered, pend_clr, irq_ack, err_mode;
  logic [IW-1:0] nx_pil, ack_level;
  logic [2:0] nx_cwp;
  logic [31:0] tbr_out, pc_out, npc_out, sv_pc_data, sv_npc_data;
  logic [6:0] sv_pc_addr, sv_npc_addr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  trap_entry_unit #(.NWIN(NW), .IRQ_W(IW)) i_trap_entry_unit (
    .clk(clk), .rst_n(rst_n), .irq_level(irq_level), .trap_code(trap_code),
    .st_et(st_et), .st_s(st_s), .st_ps(st_ps), .st_pil(st_pil), .st_cwp(st_cwp),
    .tbr_in(tbr_in), .single_vec(single_vec), .pc_in(pc_in), .npc_in(npc_in),
    .nx_et(nx_et), .nx_s(nx_s), .nx_ps(nx_ps), .nx_pil(nx_pil), .nx_cwp(nx_cwp),
    .tbr_out(tbr_out), .pc_out(pc_out), .npc_out(npc_out), .sv_we(sv_we),
    .sv_pc_addr(sv_pc_addr), .sv_pc_data(sv_pc_data), .sv_npc_addr(sv_npc_addr),
    .sv_npc_data(sv_npc_data), .entered(entered), .pend_clr(pend_clr),
    .irq_ack(irq_ack), .ack_level(ack_level), .err_mode(err_mode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    irq_level = v.lvl; trap_code = v.code; st_et = v.et; st_s = v.s;
    st_pil = v.pil; st_cwp = v.cwp; single_vec = v.sv; st_ps = ~v.s;
  endtask

  task automatic go_idle();
    irq_level = '0; trap_code = '0; st_et = 1'b1; st_s = 1'b0; st_ps = 1'b0;
    st_pil = '0; st_cwp = 3'd3; single_vec = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    go_idle();
    repeat (3) @(negedge clk);
    // R11: reset values
    chk("R11 s", 32'(nx_s), 1);
    chk("R11 et", 32'(nx_et), 0);
    chk("R11 cwp", 32'(nx_cwp), 0);
    chk("R11 pc", pc_out, 0);
    chk("R11 npc", npc_out, 4);
    chk("R11 pulses", {28'd0, entered, pend_clr, irq_ack, sv_we}, 0);
    chk("R11 err", 32'(err_mode), 0);
    rst_n = 1'b1;

    // Table walk: R1 R2 R3 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic irq_ok, trap_ok, take;
      logic [7:0] tt;
      logic [31:0] xtbr, xpc;
      logic [2:0] ncwp;
      v = VEC[i];
      @(negedge clk);
      drive(v);
      irq_ok  = (v.lvl != 0) && v.et && (v.code == 0) && ((v.lvl == 4'd15) || (v.lvl > v.pil));
      trap_ok = (v.code != 0) && (v.code != 9'h100) && v.et;
      take    = irq_ok || trap_ok;
      tt      = (v.code != 0) ? v.code[7:0] : 8'(16 + int'(v.lvl));
      xtbr    = (TBR & 32'hFFFF_F000) | (32'(tt) << 4);
      xpc     = v.sv ? (TBR & 32'hFFFF_F000) : xtbr;
      ncwp    = 3'((int'(v.cwp) + 7) % 8);
      @(negedge clk);
      chk("R1 table take", 32'(entered), 32'(v.x_take));
      chk("R1 model take", 32'(entered), 32'(take));
      chk("R2 ack", 32'(irq_ack), 32'(v.x_ack));
      if (v.x_ack) chk("R2 ack level", 32'(ack_level), 32'(v.lvl));
      chk("R3 clr", 32'(pend_clr), 32'(trap_ok || (v.code == 9'h100)));
      if (take) begin
        chk("R5 tbr", tbr_out, xtbr);
        chk("R6 et/ps/s", {29'd0, nx_et, nx_ps, nx_s}, {29'd0, 1'b0, v.s, 1'b1});
        chk("R7 cwp", 32'(nx_cwp), 32'(ncwp));
        chk("R8 we", 32'(sv_we), 1);
        chk("R8 pc addr", 32'(sv_pc_addr), 32'((int'(ncwp) * 16 + 17) % 128));
        chk("R8 npc addr", 32'(sv_npc_addr), 32'((int'(ncwp) * 16 + 18) % 128));
        chk("R8 pc data", sv_pc_data, PC0);
        chk("R8 npc data", sv_npc_data, NPC0);
        chk("R9 pc", pc_out, xpc);
        chk("R9 npc", npc_out, xpc + 4);
      end else if (v.code == 9'h100) begin
        chk("R10 pc", pc_out, 0);
        chk("R10 npc", npc_out, 4);
        chk("R10 cwp kept", 32'(nx_cwp), 32'(v.cwp));
      end else begin
        chk("R12 pc pass", pc_out, PC0);
        chk("R12 cwp pass", 32'(nx_cwp), 32'(v.cwp));
        chk("R12 no we", 32'(sv_we), 0);
      end
      go_idle();
      if (v.x_ack) begin
        @(negedge clk);
        chk("R2 ack one cycle", 32'(irq_ack), 0);
      end
    end

    // R12: idle pass-through
    @(negedge clk);
    chk("R12 tbr pass", tbr_out, TBR);
    chk("R12 npc pass", npc_out, NPC0);
    chk("R12 no pulse", {28'd0, entered, pend_clr, irq_ack, sv_we}, 0);

    // R4: trap while disabled -> sticky error mode
    trap_code = 9'h003; st_et = 1'b0;
    @(negedge clk);
    chk("R4 err set", 32'(err_mode), 1);
    chk("R4 no entry", 32'(entered), 0);
    chk("R4 pc not vectored", pc_out, PC0);
    trap_code = 9'h005; st_et = 1'b1; irq_level = 4'd15;
    @(negedge clk);
    chk("R4 blocked entry", 32'(entered), 0);
    chk("R4 no clr", 32'(pend_clr), 0);
    chk("R4 err sticky", 32'(err_mode), 1);
    go_idle();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R4 reset clears", 32'(err_mode), 0);
    chk("R11 npc after reset", npc_out, 4);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule